// File: doc/BRIEF.md
# Bank Row Timing Tracker

This block sits beside a DRAM command scheduler and keeps, for every bank of a DDR4 device, whether a row is open and how long each per-bank timing window still has to run. On every memory-clock cycle it presents, per bank, whether an activate, a column access (read or write) or a precharge would be legal. It also presents whether a refresh or a mode-register write would be legal. The scheduler picks a command using these flags and reports the issued command back on a strobe. The tracker then updates the bank state and restarts the relevant countdowns.

Timing limits arrive as whole memory-clock cycle counts that were rounded up beforehand. They are captured while reset is held. Each limit runs on its own saturating down-counter, one set per bank plus two global counters for refresh recovery and mode-register spacing. A command reported while it is not legal changes no state and raises a sticky violation flag.

Top module: `bank_row_tracker`

## Requirements
- R1: While and after reset, with no command issued, every bank is closed, every bit of `mayAct` is 1, every bit of `mayCas` and `mayPre` is 0, `mayRef` and `mayMrs` are 1, and `violation` is 0.
- R2: After an activate to a bank is sampled, `mayCas` for that bank stays 0 until that activate lies tRCD cycles back. A read or write issued on the first permitted cycle is therefore exactly tRCD cycles later, and `mayAct` for that bank is 0 while it is open.
- R3: After an activate, `mayPre` for that bank stays 0 until the activate lies tRAS cycles back.
- R4: After a write to a bank, `mayPre` for that bank stays 0 until the write lies tWR cycles back.
- R5: A legal precharge closes the bank. Its `mayCas` and `mayPre` fall to 0, and its `mayAct` stays 0 until the precharge lies tRP cycles back.
- R6: A refresh is legal only when all banks are closed, no bank's precharge window is running, and no refresh window is running. After a refresh, `mayAct` is 0 for every bank and `mayRef` is 0 for tRFC cycles.
- R7: A mode-register write is legal only when all banks are closed and the previous one lies at least tMRD cycles back.
- R8: Command codes on `cmdType` are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode-register write, and 7 reserved. The reserved code is always illegal. Any illegal command with `cmdValid` high sets `violation`, which stays 1 until reset.
- R9: An illegal command changes no bank state. A read to a closed bank does not open it, a second activate to an open bank does not restart its tRCD window, and an early precharge does not close the bank.
- R10: The bank index is `cmdGroup` × 2^BA_W + `cmdBank`, which is bit k of every per-bank flag. Banks are tracked independently.
- R11: Timing counts are captured only while `rst` is high, and changing the `cfg*` inputs afterwards has no effect. A count of 0 or 1 imposes no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset; timing counts captured while high |
| cfgTrcd | input | CNT_W | Activate to read/write, cycles |
| cfgTras | input | CNT_W | Activate to precharge, cycles |
| cfgTrp | input | CNT_W | Precharge to activate, cycles |
| cfgTwr | input | CNT_W | Write to precharge, cycles |
| cfgTrfc | input | CNT_W | Refresh to activate, cycles |
| cfgTmrd | input | CNT_W | Mode-register write to mode-register write, cycles |
| cmdValid | input | 1 | A command was issued this cycle |
| cmdType | input | 3 | Command code (see R8) |
| cmdGroup | input | BG_W | Bank group of the command |
| cmdBank | input | BA_W | Bank within the group |
| mayAct | output | 2^(BG_W+BA_W) | Per-bank activate is legal |
| mayCas | output | 2^(BG_W+BA_W) | Per-bank read or write is legal |
| mayPre | output | 2^(BG_W+BA_W) | Per-bank precharge is legal |
| mayRef | output | 1 | Refresh is legal |
| mayMrs | output | 1 | Mode-register write is legal |
| violation | output | 1 | Sticky: an illegal command was issued |

## Verification
Each command is sampled on one rising edge and every flag is combinational from registered counters. A window of N cycles therefore loads N−1 and shows its flag as 1 on the cycle N−1 edges after the sampling edge. The bench reads every flag at the falling edge after a known number of rising edges. It checks the last blocked cycle, N−2 edges after the command, and the first open cycle, N−1 edges after it. The violation flag and the unchanged bank state after an illegal command are checked on the falling edge directly after the edge that sampled that command.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

  // Widest bank selector carried in the strobe bundle.
  parameter int unsigned SEL_W = 8;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_RSV = 3'd7
  } cmd_e;

  // Strobes from control to datapath; only legal commands produce them.
  typedef struct packed {
    logic             doAct;
    logic             doWr;
    logic             doPre;
    logic             doRef;
    logic             doMrs;
    logic [SEL_W-1:0] bank;
  } strobe_t;

endpackage

// File: rtl/bank_trk_downcnt.sv
module bank_trk_downcnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/bank_trk_slice.sv
module bank_trk_slice #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             doAct,
  input  logic             doWr,
  input  logic             doPre,
  input  logic [CNT_W-1:0] ldRcd,
  input  logic [CNT_W-1:0] ldRas,
  input  logic [CNT_W-1:0] ldRp,
  input  logic [CNT_W-1:0] ldWr,
  output logic             isActive,
  output logic             rcdDone,
  output logic             rasDone,
  output logic             rpDone,
  output logic             wrDone
);

  always_ff @(posedge clk) begin
    if (rst) begin
      isActive <= 1'b0;
    end else if (doAct) begin
      isActive <= 1'b1;
    end else if (doPre) begin
      isActive <= 1'b0;
    end
  end

  bank_trk_downcnt #(.CNT_W(CNT_W)) u_rcd (
    .clk(clk), .rst(rst), .load(doAct), .loadVal(ldRcd), .done(rcdDone)
  );

  bank_trk_downcnt #(.CNT_W(CNT_W)) u_ras (
    .clk(clk), .rst(rst), .load(doAct), .loadVal(ldRas), .done(rasDone)
  );

  bank_trk_downcnt #(.CNT_W(CNT_W)) u_rp (
    .clk(clk), .rst(rst), .load(doPre), .loadVal(ldRp), .done(rpDone)
  );

  bank_trk_downcnt #(.CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst(rst), .load(doWr), .loadVal(ldWr), .done(wrDone)
  );

endmodule

// File: rtl/bank_trk_dp.sv
module bank_trk_dp
  import bank_trk_pkg::*;
#(
  parameter int unsigned NB    = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfgTrcd,
  input  logic [CNT_W-1:0] cfgTras,
  input  logic [CNT_W-1:0] cfgTrp,
  input  logic [CNT_W-1:0] cfgTwr,
  input  logic [CNT_W-1:0] cfgTrfc,
  input  logic [CNT_W-1:0] cfgTmrd,
  input  strobe_t          stb,
  output logic [NB-1:0]    activeVec,
  output logic [NB-1:0]    rcdDone,
  output logic [NB-1:0]    rasDone,
  output logic [NB-1:0]    rpDone,
  output logic [NB-1:0]    wrDone,
  output logic             rfcDone,
  output logic             mrdDone
);

  // A window of N cycles loads N-1: the flag opens N-1 edges after the command edge.
  function automatic logic [CNT_W-1:0] satDec(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [CNT_W-1:0] ldRcd, ldRas, ldRp, ldWr, ldRfc, ldMrd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ldRcd <= satDec(cfgTrcd);
      ldRas <= satDec(cfgTras);
      ldRp  <= satDec(cfgTrp);
      ldWr  <= satDec(cfgTwr);
      ldRfc <= satDec(cfgTrfc);
      ldMrd <= satDec(cfgTmrd);
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic bankHit;
    assign bankHit = (stb.bank == SEL_W'(i));

    bank_trk_slice #(.CNT_W(CNT_W)) u_slice (
      .clk      (clk),
      .rst      (rst),
      .doAct    (stb.doAct && bankHit),
      .doWr     (stb.doWr  && bankHit),
      .doPre    (stb.doPre && bankHit),
      .ldRcd    (ldRcd),
      .ldRas    (ldRas),
      .ldRp     (ldRp),
      .ldWr     (ldWr),
      .isActive (activeVec[i]),
      .rcdDone  (rcdDone[i]),
      .rasDone  (rasDone[i]),
      .rpDone   (rpDone[i]),
      .wrDone   (wrDone[i])
    );
  end

  bank_trk_downcnt #(.CNT_W(CNT_W)) u_rfc (
    .clk(clk), .rst(rst), .load(stb.doRef), .loadVal(ldRfc), .done(rfcDone)
  );

  bank_trk_downcnt #(.CNT_W(CNT_W)) u_mrd (
    .clk(clk), .rst(rst), .load(stb.doMrs), .loadVal(ldMrd), .done(mrdDone)
  );

endmodule

// File: rtl/bank_trk_ctrl.sv
module bank_trk_ctrl
  import bank_trk_pkg::*;
#(
  parameter int unsigned BG_W = 2,
  parameter int unsigned BA_W = 2,
  localparam int unsigned IDX_W = BG_W + BA_W,
  localparam int unsigned NB    = 1 << IDX_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmdValid,
  input  logic [2:0]      cmdType,
  input  logic [BG_W-1:0] cmdGroup,
  input  logic [BA_W-1:0] cmdBank,
  input  logic [NB-1:0]   activeVec,
  input  logic [NB-1:0]   rcdDone,
  input  logic [NB-1:0]   rasDone,
  input  logic [NB-1:0]   rpDone,
  input  logic [NB-1:0]   wrDone,
  input  logic            rfcDone,
  input  logic            mrdDone,
  output logic [NB-1:0]   mayAct,
  output logic [NB-1:0]   mayCas,
  output logic [NB-1:0]   mayPre,
  output logic            mayRef,
  output logic            mayMrs,
  output logic            violation,
  output strobe_t         stb
);

  logic [IDX_W-1:0] idx;
  logic             allIdle;
  logic             legal;
  cmd_e             op;

  assign idx     = {cmdGroup, cmdBank};
  assign allIdle = (activeVec == '0);
  assign op      = cmd_e'(cmdType);

  always_comb begin
    mayAct = ~activeVec & rpDone & {NB{rfcDone}};
    mayCas = activeVec & rcdDone;
    mayPre = activeVec & rasDone & wrDone;
    mayRef = allIdle && (&rpDone) && rfcDone;
    mayMrs = allIdle && mrdDone;
  end

  always_comb begin
    unique case (op)
      CMD_NOP:        legal = 1'b1;
      CMD_ACT:        legal = mayAct[idx];
      CMD_RD, CMD_WR: legal = mayCas[idx];
      CMD_PRE:        legal = mayPre[idx];
      CMD_REF:        legal = mayRef;
      CMD_MRS:        legal = mayMrs;
      default:        legal = 1'b0;
    endcase
  end

  always_comb begin
    stb      = '0;
    stb.bank = SEL_W'(idx);
    if (cmdValid && legal) begin
      unique case (op)
        CMD_ACT: stb.doAct = 1'b1;
        CMD_WR:  stb.doWr  = 1'b1;
        CMD_PRE: stb.doPre = 1'b1;
        CMD_REF: stb.doRef = 1'b1;
        CMD_MRS: stb.doMrs = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      violation <= 1'b0;
    end else if (cmdValid && !legal) begin
      violation <= 1'b1;
    end
  end

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import bank_trk_pkg::*;
#(
  parameter int unsigned BG_W  = 2,
  parameter int unsigned BA_W  = 2,
  parameter int unsigned CNT_W = 8,
  localparam int unsigned NB   = 1 << (BG_W + BA_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfgTrcd,
  input  logic [CNT_W-1:0] cfgTras,
  input  logic [CNT_W-1:0] cfgTrp,
  input  logic [CNT_W-1:0] cfgTwr,
  input  logic [CNT_W-1:0] cfgTrfc,
  input  logic [CNT_W-1:0] cfgTmrd,
  input  logic             cmdValid,
  input  logic [2:0]       cmdType,
  input  logic [BG_W-1:0]  cmdGroup,
  input  logic [BA_W-1:0]  cmdBank,
  output logic [NB-1:0]    mayAct,
  output logic [NB-1:0]    mayCas,
  output logic [NB-1:0]    mayPre,
  output logic             mayRef,
  output logic             mayMrs,
  output logic             violation
);

  strobe_t       stb;
  logic [NB-1:0] activeVec, rcdDone, rasDone, rpDone, wrDone;
  logic          rfcDone, mrdDone;

  bank_trk_ctrl #(.BG_W(BG_W), .BA_W(BA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmdValid  (cmdValid),
    .cmdType   (cmdType),
    .cmdGroup  (cmdGroup),
    .cmdBank   (cmdBank),
    .activeVec (activeVec),
    .rcdDone   (rcdDone),
    .rasDone   (rasDone),
    .rpDone    (rpDone),
    .wrDone    (wrDone),
    .rfcDone   (rfcDone),
    .mrdDone   (mrdDone),
    .mayAct    (mayAct),
    .mayCas    (mayCas),
    .mayPre    (mayPre),
    .mayRef    (mayRef),
    .mayMrs    (mayMrs),
    .violation (violation),
    .stb       (stb)
  );

  bank_trk_dp #(.NB(NB), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .cfgTrcd   (cfgTrcd),
    .cfgTras   (cfgTras),
    .cfgTrp    (cfgTrp),
    .cfgTwr    (cfgTwr),
    .cfgTrfc   (cfgTrfc),
    .cfgTmrd   (cfgTmrd),
    .stb       (stb),
    .activeVec (activeVec),
    .rcdDone   (rcdDone),
    .rasDone   (rasDone),
    .rpDone    (rpDone),
    .wrDone    (wrDone),
    .rfcDone   (rfcDone),
    .mrdDone   (mrdDone)
  );

endmodule

// File: rtl/bank_trk_chk.sv
module bank_trk_chk
  import bank_trk_pkg::*;
#(
  parameter int unsigned BG_W = 2,
  parameter int unsigned BA_W = 2,
  localparam int unsigned IDX_W = BG_W + BA_W,
  localparam int unsigned NB    = 1 << IDX_W
) (
  input logic            clk,
  input logic            rst,
  input logic            cmdValid,
  input logic [2:0]      cmdType,
  input logic [BG_W-1:0] cmdGroup,
  input logic [BA_W-1:0] cmdBank,
  input logic [NB-1:0]   mayAct,
  input logic [NB-1:0]   mayPre,
  input logic            mayRef,
  input logic            mayMrs,
  input logic            violation,
  input logic [NB-1:0]   activeVec,
  input logic            rfcDone,
  input logic            mrdDone
);

  logic [IDX_W-1:0] idx;
  assign idx = {cmdGroup, cmdBank};

  // R8: the violation flag never clears without reset
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation);

  // R9: an activate that is not legal flags and leaves every bank as it was
  a_r9_illegal_act_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdType == 3'(CMD_ACT) && !mayAct[idx])
      |=> (violation && $stable(activeVec)));

  // R5: a legal precharge closes the addressed bank
  a_r5_pre_closes: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdType == 3'(CMD_PRE) && mayPre[idx])
      |=> !activeVec[$past(idx)]);

  // R6: a running refresh window blocks every activate and further refresh
  a_r6_ref_lockout: assert property (@(posedge clk) disable iff (rst)
    !rfcDone |-> ((mayAct == '0) && !mayRef));

  // R7: a running mode-register window blocks the next one
  a_r7_mrs_gap: assert property (@(posedge clk) disable iff (rst)
    !mrdDone |-> !mayMrs);

endmodule

bind bank_row_tracker bank_trk_chk #(.BG_W(BG_W), .BA_W(BA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmdValid  (cmdValid),
  .cmdType   (cmdType),
  .cmdGroup  (cmdGroup),
  .cmdBank   (cmdBank),
  .mayAct    (mayAct),
  .mayPre    (mayPre),
  .mayRef    (mayRef),
  .mayMrs    (mayMrs),
  .violation (violation),
  .activeVec (activeVec),
  .rfcDone   (rfcDone),
  .mrdDone   (mrdDone)
);

// File: tb/tb_bank_row_tracker.sv
`timescale 1ns/1ps
module tb_bank_row_tracker;

  localparam int BG_W = 2, BA_W = 2, CNT_W = 8;
  localparam int NB = 1 << (BG_W + BA_W);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6, C_RSV = 3'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0] cfgTrcd = 8'd5, cfgTras = 8'd12, cfgTrp = 8'd4,
                    cfgTwr = 8'd6, cfgTrfc = 8'd20, cfgTmrd = 8'd3;
  logic cmdValid = 1'b0;
  logic [2:0] cmdType = C_NOP;
  logic [BG_W-1:0] cmdGroup = '0;
  logic [BA_W-1:0] cmdBank = '0;
  logic [NB-1:0] mayAct, mayCas, mayPre;
  logic mayRef, mayMrs, violation;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  bank_row_tracker #(.BG_W(BG_W), .BA_W(BA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst),
    .cfgTrcd(cfgTrcd), .cfgTras(cfgTras), .cfgTrp(cfgTrp),
    .cfgTwr(cfgTwr), .cfgTrfc(cfgTrfc), .cfgTmrd(cfgTmrd),
    .cmdValid(cmdValid), .cmdType(cmdType), .cmdGroup(cmdGroup), .cmdBank(cmdBank),
    .mayAct(mayAct), .mayCas(mayCas), .mayPre(mayPre),
    .mayRef(mayRef), .mayMrs(mayMrs), .violation(violation)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Called at a falling edge; advances n cycles.
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a falling edge; command sampled on the next rising edge.
  task automatic issue(input logic [2:0] c, input int g, input int b);
    cmdValid = 1'b1;
    cmdType  = c;
    cmdGroup = BG_W'(g);
    cmdBank  = BA_W'(b);
    @(negedge clk);
    cmdValid = 1'b0;
    cmdType  = C_NOP;
  endtask

  task automatic doReset(input int rcd, input int ras, input int rp, input int wr,
                         input int rfc, input int mrd);
    @(negedge clk);
    rst = 1'b1;
    cfgTrcd = CNT_W'(rcd); cfgTras = CNT_W'(ras); cfgTrp = CNT_W'(rp);
    cfgTwr = CNT_W'(wr); cfgTrfc = CNT_W'(rfc); cfgTmrd = CNT_W'(mrd);
    step(3);
    rst = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 mayAct", 32'(mayAct), 32'hFFFF);
    chk("R1 mayCas", 32'(mayCas), 0);
    chk("R1 mayPre", 32'(mayPre), 0);
    chk("R1 mayRef", 32'(mayRef), 1);
    chk("R1 mayMrs", 32'(mayMrs), 1);
    chk("R1 violation", 32'(violation), 0);
  endtask

  // Bank 3 = group 0, bank 3.
  task automatic testRcd();
    issue(C_ACT, 0, 3);
    chk("R2 mayAct open bank", 32'(mayAct[3]), 0);
    chk("R2 mayCas j0", 32'(mayCas[3]), 0);
    chk("R10 other bank untouched", 32'({mayAct[5], mayCas[5]}), 32'b10);
    step(3);
    chk("R2 mayCas last blocked", 32'(mayCas[3]), 0);
    step(1);
    chk("R2 mayCas first open", 32'(mayCas[3]), 1);
  endtask

  task automatic testRas();
    step(6);
    chk("R3 mayPre last blocked", 32'(mayPre[3]), 0);
    step(1);
    chk("R3 mayPre first open", 32'(mayPre[3]), 1);
  endtask

  task automatic testWr();
    issue(C_WR, 0, 3);
    chk("R4 mayPre after write", 32'(mayPre[3]), 0);
    step(4);
    chk("R4 mayPre last blocked", 32'(mayPre[3]), 0);
    step(1);
    chk("R4 mayPre first open", 32'(mayPre[3]), 1);
    chk("R4 no violation", 32'(violation), 0);
  endtask

  task automatic testPre();
    issue(C_PRE, 0, 3);
    chk("R5 closed cas/pre", 32'({mayCas[3], mayPre[3]}), 0);
    chk("R6 ref blocked by precharge window", 32'(mayRef), 0);
    step(2);
    chk("R5 mayAct last blocked", 32'(mayAct[3]), 0);
    step(1);
    chk("R5 mayAct first open", 32'(mayAct[3]), 1);
    chk("R6 ref legal once idle", 32'(mayRef), 1);
  endtask

  task automatic testRef();
    issue(C_REF, 0, 0);
    chk("R6 act locked j0", 32'(mayAct), 0);
    step(18);
    chk("R6 act locked last", 32'(mayAct), 0);
    chk("R6 ref locked last", 32'(mayRef), 0);
    step(1);
    chk("R6 act free", 32'(mayAct), 32'hFFFF);
    chk("R6 ref free", 32'(mayRef), 1);
  endtask

  task automatic testMrs();
    issue(C_MRS, 0, 0);
    chk("R7 mrs j0", 32'(mayMrs), 0);
    step(1);
    chk("R7 mrs last blocked", 32'(mayMrs), 0);
    step(1);
    chk("R7 mrs first open", 32'(mayMrs), 1);
    chk("R7 no violation", 32'(violation), 0);
  endtask

  task automatic testViolation();
    doReset(5, 12, 4, 6, 20, 3);
    // read to closed bank 6 (group 1, bank 2)
    issue(C_RD, 1, 2);
    chk("R8 read to closed bank", 32'(violation), 1);
    chk("R9 closed bank stays closed", 32'({mayAct[6], mayCas[6]}), 32'b10);
    doReset(5, 12, 4, 6, 20, 3);
    chk("R1 reset clears violation", 32'(violation), 0);
    issue(C_ACT, 0, 2);
    chk("R7 mrs blocked with open bank", 32'(mayMrs), 0);
    chk("R6 ref blocked with open bank", 32'(mayRef), 0);
    step(4);
    chk("R2 bank2 cas open", 32'(mayCas[2]), 1);
    issue(C_ACT, 0, 2);
    chk("R8 act to open bank", 32'(violation), 1);
    chk("R9 tRCD not restarted", 32'(mayCas[2]), 1);
    issue(C_PRE, 0, 2);
    chk("R9 early pre leaves bank open", 32'({mayAct[2], mayCas[2]}), 32'b01);
    step(30);
    chk("R8 sticky", 32'(violation), 1);
    doReset(5, 12, 4, 6, 20, 3);
    issue(C_RSV, 0, 0);
    chk("R8 reserved code", 32'(violation), 1);
  endtask

  task automatic testMap();
    doReset(5, 12, 4, 6, 20, 3);
    issue(C_ACT, 2, 1);
    chk("R10 group2 bank1 is index 9", 32'(mayAct), 32'hFDFF);
    issue(C_ACT, 1, 2);
    chk("R10 independent banks", 32'(mayAct), 32'hFDBF);
    chk("R10 no violation", 32'(violation), 0);
  endtask

  task automatic testCfg();
    doReset(1, 1, 0, 1, 20, 3);
    cfgTrcd = 8'd9; cfgTras = 8'd9; cfgTrp = 8'd9; cfgTwr = 8'd9;
    issue(C_ACT, 0, 0);
    chk("R11 tRCD of 1 no wait", 32'(mayCas[0]), 1);
    chk("R11 tRAS of 1 no wait", 32'(mayPre[0]), 1);
    issue(C_PRE, 0, 0);
    chk("R11 tRP of 0 no wait", 32'(mayAct[0]), 1);
    chk("R11 no violation", 32'(violation), 0);
  endtask

  initial begin
    doReset(5, 12, 4, 6, 20, 3);
    testReset();
    testRcd();
    testRas();
    testWr();
    testPre();
    testRef();
    testMrs();
    testViolation();
    testMap();
    testCfg();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule